// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation cache. It maps a virtual address to a physical address for the address space that is running now. Each cached entry stores a valid flag, a virtual page number, a physical frame number, an 8-bit address space tag and three permission bits. An entry can only hit when its tag equals the current space's tag. Because of this, a context switch does not force a flush.

Lookup is combinational. A requester presents an address, an access kind and the current tag, and gets the result in the same cycle: a hit flag, a physical address and a fault code. A miss handler outside the block walks the page tables and loads results through the insert port. An insert replaces an entry that has the same page and tag. Otherwise it takes the slot chosen by a round-robin pointer.

Two maintenance inputs remove entries. One clears the whole buffer. The other clears only the entries that belong to one tag. Inserts and flushes take effect on the next clock edge.

Top module: `asid_tlb`

## Requirements
- R1: The page number is `va[VA_W-1:OFF_W]` and the offset is `va[OFF_W-1:0]`. A lookup hits when a valid entry holds that page number and its tag equals `curAsid`. A permitted hit drives `pa = {pfn, offset}`.
- R2: A lookup misses when no entry matches. This covers an entry with the right page but another tag, and an entry whose valid flag is clear. A miss gives `hit=0`, `fault=2'b10` and `pa=0`.
- R3: Permission bits are `insProt[0]` for read, `insProt[1]` for write and `insProt[2]` for execute. `accType` is 00 for read, 01 for write and 10 for execute. The code 11 is never permitted. A hit whose entry lacks the requested permission gives `hit=1`, `fault=2'b01` and `pa=0`.
- R4: A permitted hit gives `hit=1` and `fault=2'b00`.
- R5: Lookup depends only on the current inputs and the stored state. An insert becomes visible after the next rising clock edge and not before it.
- R6: An insert whose page and tag equal those of a valid entry rewrites that entry in place. The replacement pointer does not move.
- R7: Any other insert goes to the slot named by the replacement pointer. The pointer then advances by one and wraps after the last slot.
- R8: `flushAll` clears every entry at the next edge. An insert requested in the same cycle is dropped.
- R9: `flushById` clears, at the next edge, only the entries whose tag equals `flushId`. Entries with other tags keep translating.
- R10: When an insert and `flushById` occur in the same cycle, the inserted entry survives, even if its tag equals `flushId`.
- R11: After reset every entry is invalid and the replacement pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| va | input | VA_W | Virtual address to translate |
| accType | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| curAsid | input | ASID_W | Tag of the running address space |
| insValid | input | 1 | Insert request |
| insVpn | input | VPN_W | Page number to insert |
| insPfn | input | PFN_W | Frame number to insert |
| insAsid | input | ASID_W | Tag of the inserted entry |
| insProt | input | 3 | Permissions of the inserted entry {x,w,r} |
| flushAll | input | 1 | Clear all entries |
| flushById | input | 1 | Clear the entries with tag flushId |
| flushId | input | ASID_W | Tag selected for clearing |
| hit | output | 1 | A matching entry exists |
| fault | output | 2 | 00 none, 01 protection, 10 miss |
| pa | output | PFN_W+OFF_W | Physical address (zero unless the hit is permitted) |

## Verification
An insert can arrive in the same cycle as either flush, and the two results must not be confused. The bench raises `insValid` together with `flushById` and checks that the new entry translates afterwards while the other entries with that tag are gone. It then pairs an insert with `flushAll` and checks that nothing translates. Replacement is observed only at the ports. The bench fills every slot, rewrites one entry, and then confirms which older page each new insert has evicted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PROT = 2'b01,
    FLT_MISS = 2'b10
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  // strobes from control to the entry store
  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic clrId;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insValid,
  input  logic             flushAll,
  input  logic             flushById,
  input  logic             insMatchAny,
  input  logic [IDX_W-1:0] insMatchIdx,
  output tlbStrobe_t       strb,
  output logic [IDX_W-1:0] wrIdx
);

  logic [IDX_W-1:0] victimPtr;
  logic [IDX_W-1:0] victimNext;

  always_comb begin
    strb.clrAll = flushAll;
    strb.clrId  = flushById & ~flushAll;
    strb.wrEn   = insValid & ~flushAll;
    wrIdx       = insMatchAny ? insMatchIdx : victimPtr;
    if (victimPtr == IDX_W'(ENTRIES - 1)) victimNext = '0;
    else victimNext = victimPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) victimPtr <= '0;
    else if (strb.wrEn && !insMatchAny) victimPtr <= victimNext;
  end

  // R7
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && !insMatchAny) |=>
      (victimPtr == (($past(victimPtr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victimPtr) + 1'b1)));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && insMatchAny) |=> (victimPtr == $past(victimPtr)));

  // R8
  drop_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |-> !strb.wrEn);

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 8,
  parameter int OFF_W   = 8,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [OFF_W-1:0]       lkOff,
  input  logic [1:0]             accType,
  input  logic [ASID_W-1:0]      curAsid,
  input  logic [VPN_W-1:0]       insVpn,
  input  logic [PFN_W-1:0]       insPfn,
  input  logic [ASID_W-1:0]      insAsid,
  input  logic [2:0]             insProt,
  input  logic [ASID_W-1:0]      flushId,
  input  tlbStrobe_t             strb,
  input  logic [IDX_W-1:0]       wrIdx,
  output logic                   insMatchAny,
  output logic [IDX_W-1:0]       insMatchIdx,
  output logic                   hit,
  output fault_e                 fault,
  output logic [PFN_W+OFF_W-1:0] pa
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] insMatch;
  logic [VPN_W-1:0]   entVpn  [ENTRIES];
  logic [PFN_W-1:0]   entPfn  [ENTRIES];
  logic [ASID_W-1:0]  entAsid [ENTRIES];
  logic [2:0]         entProt [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) entValid[i] <= 1'b0;
      else if (strb.clrAll) entValid[i] <= 1'b0;
      else if (strb.wrEn && wrIdx == IDX_W'(i)) entValid[i] <= 1'b1;
      else if (strb.clrId && entAsid[i] == flushId) entValid[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (strb.wrEn && wrIdx == IDX_W'(i)) begin
        entVpn[i]  <= insVpn;
        entPfn[i]  <= insPfn;
        entAsid[i] <= insAsid;
        entProt[i] <= insProt;
      end
    end

    assign lkMatch[i]  = entValid[i] && entVpn[i] == lkVpn && entAsid[i] == curAsid;
    assign insMatch[i] = entValid[i] && entVpn[i] == insVpn && entAsid[i] == insAsid;
  end

  logic [PFN_W-1:0] selPfn;
  logic [2:0]       selProt;
  logic             permit;

  always_comb begin
    selPfn      = '0;
    selProt     = '0;
    insMatchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        selPfn  = selPfn | entPfn[i];
        selProt = selProt | entProt[i];
      end
      if (insMatch[i]) insMatchIdx = insMatchIdx | IDX_W'(i);
    end
    insMatchAny = |insMatch;
    hit = |lkMatch;
    unique case (accType)
      ACC_READ:  permit = selProt[0];
      ACC_WRITE: permit = selProt[1];
      ACC_EXEC:  permit = selProt[2];
      default:   permit = 1'b0;
    endcase
    if (!hit) fault = FLT_MISS;
    else if (!permit) fault = FLT_PROT;
    else fault = FLT_NONE;
    pa = (fault == FLT_NONE) ? {selPfn, lkOff} : '0;
  end

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkMatch) && $onehot0(insMatch));

  // R5
  ins_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrEn |=> entValid[$past(wrIdx)]);

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (entValid == '0));

  // R3
  prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == FLT_PROT) |-> (hit && pa == '0));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PFN_W   = 8,
  parameter int ASID_W  = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        accType,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              insValid,
  input  logic [VPN_W-1:0]  insVpn,
  input  logic [PFN_W-1:0]  insPfn,
  input  logic [ASID_W-1:0] insAsid,
  input  logic [2:0]        insProt,
  input  logic              flushAll,
  input  logic              flushById,
  input  logic [ASID_W-1:0] flushId,
  output logic              hit,
  output logic [1:0]        fault,
  output logic [PA_W-1:0]   pa
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbStrobe_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] insMatchIdx;
  logic             insMatchAny;
  fault_e           faultCode;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .insValid(insValid), .flushAll(flushAll),
    .flushById(flushById), .insMatchAny(insMatchAny), .insMatchIdx(insMatchIdx),
    .strb(strb), .wrIdx(wrIdx)
  );

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ASID_W(ASID_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lkVpn(va[VA_W-1:OFF_W]), .lkOff(va[OFF_W-1:0]),
    .accType(accType), .curAsid(curAsid),
    .insVpn(insVpn), .insPfn(insPfn), .insAsid(insAsid), .insProt(insProt),
    .flushId(flushId), .strb(strb), .wrIdx(wrIdx),
    .insMatchAny(insMatchAny), .insMatchIdx(insMatchIdx),
    .hit(hit), .fault(faultCode), .pa(pa)
  );

  assign fault = faultCode;

  // R8
  flush_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> !hit);

  // R2
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == (fault != 2'b10)) && (fault != 2'b11));

endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  accType = '0;
  logic [7:0]  curAsid = '0;
  logic        insValid = 1'b0;
  logic [7:0]  insVpn = '0;
  logic [7:0]  insPfn = '0;
  logic [7:0]  insAsid = '0;
  logic [2:0]  insProt = '0;
  logic        flushAll = 1'b0;
  logic        flushById = 1'b0;
  logic [7:0]  flushId = '0;
  logic        hit;
  logic [1:0]  fault;
  logic [15:0] pa;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  asid_tlb dut (
    .clk(clk), .rst_n(rst_n), .va(va), .accType(accType), .curAsid(curAsid),
    .insValid(insValid), .insVpn(insVpn), .insPfn(insPfn), .insAsid(insAsid),
    .insProt(insProt), .flushAll(flushAll), .flushById(flushById), .flushId(flushId),
    .hit(hit), .fault(fault), .pa(pa)
  );

  task automatic checkOut(string req, logic eHit, logic [1:0] eFault, logic [15:0] ePa);
    testCnt++;
    if (hit !== eHit || fault !== eFault || pa !== ePa) begin
      failCnt++;
      $display("FAIL %s: va=%h got hit=%b fault=%b pa=%h, expected hit=%b fault=%b pa=%h",
               req, va, hit, fault, pa, eHit, eFault, ePa);
    end
  endtask

  task automatic look(string req, logic [15:0] a, logic [1:0] acc, logic [7:0] id,
                      logic eHit, logic [1:0] eFault, logic [15:0] ePa);
    @(negedge clk);
    va = a; accType = acc; curAsid = id;
    #1 checkOut(req, eHit, eFault, ePa);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic doInsert(logic [7:0] vpn, logic [7:0] pfn, logic [7:0] id, logic [2:0] prot);
    @(negedge clk);
    insValid = 1'b1; insVpn = vpn; insPfn = pfn; insAsid = id; insProt = prot;
    @(negedge clk);
    insValid = 1'b0;
  endtask

  // R11, R2: empty buffer after reset
  task automatic testReset();
    doReset();
    look("R11", 16'h1234, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R2",  16'h0000, 2'b00, 8'd0,  1'b0, 2'b10, 16'h0);
  endtask

  // R1, R4, R5: basic translation and insert timing
  task automatic testBasic();
    @(negedge clk);
    va = 16'h1234; accType = 2'b00; curAsid = 8'd11;
    insValid = 1'b1; insVpn = 8'h12; insPfn = 8'h91; insAsid = 8'd11; insProt = 3'b111;
    #1 checkOut("R5", 1'b0, 2'b10, 16'h0);
    @(posedge clk);
    #1 checkOut("R5", 1'b1, 2'b00, 16'h9134);
    @(negedge clk);
    insValid = 1'b0;
    look("R1", 16'h12FF, 2'b01, 8'd11, 1'b1, 2'b00, 16'h91FF);
    look("R4", 16'h1200, 2'b10, 8'd11, 1'b1, 2'b00, 16'h9100);
  endtask

  // R2: wrong tag or wrong page misses
  task automatic testTag();
    look("R2", 16'h1234, 2'b00, 8'd12, 1'b0, 2'b10, 16'h0);
    look("R2", 16'h1334, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
  endtask

  // R3: permission checking
  task automatic testProt();
    doInsert(8'h20, 8'h33, 8'd11, 3'b001);
    look("R3", 16'h20AB, 2'b00, 8'd11, 1'b1, 2'b00, 16'h33AB);
    look("R3", 16'h20AB, 2'b01, 8'd11, 1'b1, 2'b01, 16'h0);
    look("R3", 16'h20AB, 2'b10, 8'd11, 1'b1, 2'b01, 16'h0);
    look("R3", 16'h20AB, 2'b11, 8'd11, 1'b1, 2'b01, 16'h0);
    doInsert(8'h21, 8'h44, 8'd11, 3'b110);
    look("R3", 16'h2101, 2'b00, 8'd11, 1'b1, 2'b01, 16'h0);
    look("R3", 16'h2101, 2'b10, 8'd11, 1'b1, 2'b00, 16'h4401);
  endtask

  // R8: flush all, with an insert in the same cycle
  task automatic testFlushAll();
    @(negedge clk);
    flushAll = 1'b1;
    insValid = 1'b1; insVpn = 8'h55; insPfn = 8'h66; insAsid = 8'd11; insProt = 3'b111;
    @(negedge clk);
    flushAll = 1'b0; insValid = 1'b0;
    look("R8", 16'h1234, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R8", 16'h20AB, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R8", 16'h5500, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
  endtask

  // R6, R7, R11: replacement order
  task automatic testReplace();
    doReset();
    for (int i = 0; i < 8; i++) doInsert(8'h40 + 8'(i), 8'h50 + 8'(i), 8'd11, 3'b111);
    look("R7", 16'h4700, 2'b00, 8'd11, 1'b1, 2'b00, 16'h5700);
    doInsert(8'h43, 8'hEE, 8'd11, 3'b111);
    look("R6", 16'h4301, 2'b00, 8'd11, 1'b1, 2'b00, 16'hEE01);
    doInsert(8'h60, 8'h70, 8'd11, 3'b111);
    look("R7", 16'h4000, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R6", 16'h4100, 2'b00, 8'd11, 1'b1, 2'b00, 16'h5100);
    look("R7", 16'h6000, 2'b00, 8'd11, 1'b1, 2'b00, 16'h7000);
    doInsert(8'h61, 8'h71, 8'd11, 3'b111);
    look("R7", 16'h4100, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R7", 16'h4200, 2'b00, 8'd11, 1'b1, 2'b00, 16'h5200);
  endtask

  // R9, R10: flush by tag, with an insert in the same cycle
  task automatic testFlushId();
    doReset();
    doInsert(8'h10, 8'hA0, 8'd11, 3'b111);
    doInsert(8'h11, 8'hA1, 8'd12, 3'b111);
    doInsert(8'h12, 8'hA2, 8'd11, 3'b111);
    @(negedge clk);
    flushById = 1'b1; flushId = 8'd11;
    insValid = 1'b1; insVpn = 8'h13; insPfn = 8'hA3; insAsid = 8'd11; insProt = 3'b111;
    @(negedge clk);
    flushById = 1'b0; insValid = 1'b0;
    look("R9",  16'h1000, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R9",  16'h1200, 2'b00, 8'd11, 1'b0, 2'b10, 16'h0);
    look("R9",  16'h1105, 2'b00, 8'd12, 1'b1, 2'b00, 16'hA105);
    look("R10", 16'h1307, 2'b00, 8'd11, 1'b1, 2'b00, 16'hA307);
  endtask

  initial begin
    #(8 * 20000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    testReset();
    testBasic();
    testTag();
    testProt();
    testFlushAll();
    testReplace();
    testFlushId();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule